// File: doc/BRIEF.md
# Start/End Pulse Window Monitor

This block watches three single-bit signals and reports whether they follow a windowed handshake. A level `win_en`, driven by the design under observation, opens a window. The environment must then send exactly one single-cycle start pulse (`start_pls`) followed by exactly one single-cycle end pulse (`end_pls`). The end pulse may come in the same cycle as the start pulse or any number of cycles later. The window opens one cycle after the rising edge of `win_en`. The level must stay high from the start pulse until the end pulse. Once a pair has completed, another pair is only legal after `win_en` has gone low and risen again.

The monitor is synthesizable and runs in one clock domain with an active-low reset. It samples the three inputs on every rising clock edge. It reports through registered outputs: a one-cycle error strobe with a 3-bit violation code, and a one-cycle completion pulse for each legal pair. It can be instantiated next to the logic it supervises, or inside an emulation or prototyping build.

Top module: `pulse_window_mon`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after its release, `err_strobe`, `err_code` and `done_pulse` are all 0, whatever the inputs are.
- R2: All outputs are registered. A start pulse in some cycle after the rising cycle of `win_en`, followed by an end pulse in a later cycle with `win_en` held high, raises `done_pulse` for exactly one cycle: the cycle after the end pulse is sampled. No error is raised.
- R3: A start pulse and an end pulse in the same cycle of an open window form a legal pair. `done_pulse` is raised in the following cycle.
- R4: While `win_en` is high and the window is already open, a start or end input that is high in two consecutive sampled cycles raises `err_strobe` with `err_code` = 1 (pulse too long) in the cycle after the second sample. The state is not advanced.
- R5: An end pulse without a start pulse while the window is waiting for its start raises code 2 (end before start).
- R6: A new, non-consecutive start pulse while waiting for the end pulse raises code 3 (extra pulse). So does any pulse after the pair has completed within the same window.
- R7: If `win_en` is low in a cycle while a start has been seen and the end has not, code 4 (window dropped) is raised.
- R8: A start or end input that is high while `win_en` is low, or in the cycle in which `win_en` rises, raises code 5 (activity outside window).
- R9: If `win_en` falls after opening, before any pulse, the monitor returns to idle without an error.
- R10: After `win_en` falls and rises again, a new legal pair completes normally. A repeated rise gives each window its own single pair.
- R11: Only one code is reported per cycle, chosen by this priority: window dropped (4) over outside activity (5) over pulse too long (1) over the order errors (2 and 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_en | input | 1 | Window enable level from the observed design |
| start_pls | input | 1 | Start pulse from the environment |
| end_pls | input | 1 | End pulse from the environment |
| err_strobe | output | 1 | One-cycle violation strobe |
| err_code | output | 3 | Violation code, 0 when no violation |
| done_pulse | output | 1 | One-cycle pulse after a legal pair |

## Verification
The bound checker checks these rules on every cycle:
- the completion pulse only ever follows a sampled end pulse with the level high, and never lasts two cycles;
- the completion pulse and the error strobe never coincide;
- a drop of the level while waiting for the end pulse yields code 4;
- activity while the level is low yields code 5;
- an over-long start pulse yields code 1;
- an early end pulse yields code 2;
- a fall while armed is silent.

The reset state and the exact cycle of completion need the bench's scenarios. So do the sweep of lead and gap lengths for legal pairs, the rule that a fresh rise permits a new pair, and the priority between codes that can both apply in the same cycle.

// File: rtl/pwm_pkg.sv
`timescale 1ns/1ps
package pwm_pkg;

  localparam int CODE_W = 3;
  localparam int STATE_W = 2;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE   = 2'd0,
    ST_ARMED  = 2'd1,
    ST_WAIT_B = 2'd2,
    ST_DONE   = 2'd3
  } pwm_state_e;

  typedef enum logic [CODE_W-1:0] {
    ERR_NONE  = 3'd0,
    ERR_LONG  = 3'd1,
    ERR_ORDER = 3'd2,
    ERR_EXTRA = 3'd3,
    ERR_DROP  = 3'd4,
    ERR_QUIET = 3'd5
  } pwm_err_e;

  // One sampled cycle of the three inputs plus their history.
  typedef struct packed {
    logic win;
    logic win_rise;
    logic strt;
    logic strt_long;
    logic stop;
    logic stop_long;
  } pwm_obs_t;

  // A level that was also high at the previous sample.
  function automatic logic held_over(input logic now_v, input logic prev_v);
    return now_v & prev_v;
  endfunction

  // A level that was low at the previous sample.
  function automatic logic rising(input logic now_v, input logic prev_v);
    return now_v & ~prev_v;
  endfunction

  // Arbitrate a cycle's findings by fixed priority.
  function automatic pwm_err_e pick_error(input logic drop, input logic quiet,
                                          input logic lng, input logic order,
                                          input logic extra);
    if (drop)       return ERR_DROP;
    else if (quiet) return ERR_QUIET;
    else if (lng)   return ERR_LONG;
    else if (order) return ERR_ORDER;
    else if (extra) return ERR_EXTRA;
    else            return ERR_NONE;
  endfunction

endpackage

// File: rtl/pwm_history.sv
`timescale 1ns/1ps
module pwm_history
  import pwm_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     win,
  input  logic     strt,
  input  logic     stop,
  output pwm_obs_t obs
);

  logic win_q;
  logic strt_q;
  logic stop_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_q  <= 1'b0;
      strt_q <= 1'b0;
      stop_q <= 1'b0;
    end else begin
      win_q  <= win;
      strt_q <= strt;
      stop_q <= stop;
    end
  end

  always_comb begin
    obs.win       = win;
    obs.win_rise  = rising(win, win_q);
    obs.strt      = strt;
    obs.strt_long = held_over(strt, strt_q);
    obs.stop      = stop;
    obs.stop_long = held_over(stop, stop_q);
  end

endmodule

// File: rtl/pwm_fsm.sv
`timescale 1ns/1ps
module pwm_fsm
  import pwm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  pwm_obs_t   obs,
  output pwm_state_e state,
  output pwm_err_e   nxt_err,
  output logic       nxt_done
);

  pwm_state_e nxt_state;
  logic any_pls;
  logic any_long;
  logic f_drop, f_quiet, f_long, f_order, f_extra;
  logic advance_ok;

  assign any_pls  = obs.strt | obs.stop;
  assign any_long = obs.strt_long | obs.stop_long;

  // Findings for this cycle, each independent of the others.
  always_comb begin
    f_drop  = ~obs.win & (state == ST_WAIT_B);
    f_quiet = any_pls & (~obs.win | obs.win_rise);
    f_long  = obs.win & ~obs.win_rise & any_long;
    f_order = obs.win & ~obs.win_rise & (state == ST_ARMED) & obs.stop & ~obs.strt;
    f_extra = obs.win & ~obs.win_rise &
              (((state == ST_WAIT_B) & obs.strt) | ((state == ST_DONE) & any_pls));
  end

  assign nxt_err    = pick_error(f_drop, f_quiet, f_long, f_order, f_extra);
  assign advance_ok = obs.win & ~obs.win_rise & (nxt_err == ERR_NONE);

  always_comb begin
    nxt_state = state;
    nxt_done  = 1'b0;
    if (!obs.win) begin
      nxt_state = ST_IDLE;
    end else if (obs.win_rise) begin
      nxt_state = ST_ARMED;
    end else if (advance_ok) begin
      unique case (state)
        ST_ARMED: begin
          if (obs.strt && obs.stop) begin
            nxt_state = ST_DONE;
            nxt_done  = 1'b1;
          end else if (obs.strt) begin
            nxt_state = ST_WAIT_B;
          end
        end
        ST_WAIT_B: begin
          if (obs.stop) begin
            nxt_state = ST_DONE;
            nxt_done  = 1'b1;
          end
        end
        default: nxt_state = state;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt_state;
  end

endmodule

// File: rtl/pwm_report.sv
`timescale 1ns/1ps
module pwm_report
  import pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  pwm_err_e          nxt_err,
  input  logic              nxt_done,
  output logic              err_strobe,
  output logic [CODE_W-1:0] err_code,
  output logic              done_pulse
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_strobe <= 1'b0;
      err_code   <= '0;
      done_pulse <= 1'b0;
    end else begin
      err_strobe <= (nxt_err != ERR_NONE);
      err_code   <= nxt_err;
      done_pulse <= nxt_done;
    end
  end

endmodule

// File: rtl/pulse_window_mon.sv
`timescale 1ns/1ps
module pulse_window_mon
  import pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              win_en,
  input  logic              start_pls,
  input  logic              end_pls,
  output logic              err_strobe,
  output logic [CODE_W-1:0] err_code,
  output logic              done_pulse
);

  pwm_obs_t   obs;
  pwm_state_e state;
  pwm_err_e   nxt_err;
  logic       nxt_done;

  // Named internal events, visible to the bound checker.
  logic st_armed;
  logic st_wait_b;
  logic win_rise;

  pwm_history u_hist (
    .clk  (clk),
    .rst_n(rst_n),
    .win  (win_en),
    .strt (start_pls),
    .stop (end_pls),
    .obs  (obs)
  );

  pwm_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .obs     (obs),
    .state   (state),
    .nxt_err (nxt_err),
    .nxt_done(nxt_done)
  );

  pwm_report u_rep (
    .clk       (clk),
    .rst_n     (rst_n),
    .nxt_err   (nxt_err),
    .nxt_done  (nxt_done),
    .err_strobe(err_strobe),
    .err_code  (err_code),
    .done_pulse(done_pulse)
  );

  assign st_armed  = (state == ST_ARMED);
  assign st_wait_b = (state == ST_WAIT_B);
  assign win_rise  = obs.win_rise;

endmodule

// File: rtl/pwm_checker.sv
`timescale 1ns/1ps
module pwm_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       win_en,
  input logic       start_pls,
  input logic       end_pls,
  input logic       err_strobe,
  input logic [2:0] err_code,
  input logic       done_pulse,
  input logic       st_armed,
  input logic       st_wait_b,
  input logic       win_rise
);

  p_done_after_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> ($past(end_pls) && $past(win_en)));

  p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !done_pulse);

  p_done_err_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_pulse, err_strobe}));

  p_long_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (win_en && !win_rise && start_pls && $past(start_pls)) |=> (err_strobe && err_code == 3'd1));

  p_end_early_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_armed && win_en && !win_rise && end_pls && !start_pls && !$past(end_pls))
      |=> (err_strobe && err_code == 3'd2));

  p_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wait_b && !win_en) |=> (err_strobe && err_code == 3'd4));

  p_quiet_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_en && !st_wait_b && (start_pls || end_pls)) |=> (err_strobe && err_code == 3'd5));

  p_armed_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_armed && !win_en && !start_pls && !end_pls) |=> (!err_strobe && !done_pulse));

endmodule

bind pulse_window_mon pwm_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .win_en    (win_en),
  .start_pls (start_pls),
  .end_pls   (end_pls),
  .err_strobe(err_strobe),
  .err_code  (err_code),
  .done_pulse(done_pulse),
  .st_armed  (st_armed),
  .st_wait_b (st_wait_b),
  .win_rise  (win_rise)
);

// File: tb/pulse_window_mon_bench.sv
`timescale 1ns/1ps
module pulse_window_mon_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       win_en = 1'b0;
  logic       start_pls = 1'b0;
  logic       end_pls = 1'b0;
  logic       err_strobe;
  logic [2:0] err_code;
  logic       done_pulse;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  pulse_window_mon u_pulse_window_mon (
    .clk(clk), .rst_n(rst_n), .win_en(win_en), .start_pls(start_pls),
    .end_pls(end_pls), .err_strobe(err_strobe), .err_code(err_code),
    .done_pulse(done_pulse)
  );

  task automatic check_out(input logic [2:0] e_code, input logic e_done, input string tag);
    logic e_err;
    e_err = (e_code != 3'd0);
    checks++;
    if (err_strobe !== e_err || err_code !== e_code || done_pulse !== e_done) begin
      errors++;
      $display("FAIL %s: got err=%b code=%0d done=%b, expected err=%b code=%0d done=%b",
               tag, err_strobe, err_code, done_pulse, e_err, e_code, e_done);
    end
  endtask

  // Drive one cycle's inputs, then check outputs just after the sampling edge.
  task automatic step(input logic c, input logic a, input logic b,
                      input logic [2:0] e_code, input logic e_done, input string tag);
    @(negedge clk);
    win_en = c; start_pls = a; end_pls = b;
    @(posedge clk);
    #1;
    check_out(e_code, e_done, tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, 3'd0, 1'b0, "R9 idle quiet");
  endtask

  initial begin
    // R1: reset holds outputs low even with activity.
    win_en = 1'b1; start_pls = 1'b1; end_pls = 1'b1;
    repeat (3) @(posedge clk);
    #1 check_out(3'd0, 1'b0, "R1 during reset");
    @(negedge clk);
    win_en = 1'b0; start_pls = 1'b0; end_pls = 1'b0;
    rst_n = 1'b1;
    @(posedge clk); #1 check_out(3'd0, 1'b0, "R1 first cycle after reset");
    idle(2);

    // R2: basic legal pair.
    step(1, 0, 0, 0, 0, "R2 rise");
    step(1, 1, 0, 0, 0, "R2 start");
    step(1, 0, 0, 0, 0, "R2 gap");
    step(1, 0, 1, 0, 1, "R2 end gives done");
    step(1, 0, 0, 0, 0, "R2 done one cycle");
    step(0, 0, 0, 0, 0, "R2 fall after done");

    // R2/R3 sweep: lead cycles before start, gap cycles to end (0 = same cycle).
    for (int lead = 0; lead < 4; lead++) begin
      for (int gap = 0; gap < 7; gap++) begin
        step(1, 0, 0, 0, 0, "R2 sweep rise");
        for (int k = 0; k < lead; k++) step(1, 0, 0, 0, 0, "R2 sweep lead");
        if (gap == 0) begin
          step(1, 1, 1, 0, 1, "R3 sweep same-cycle pair");
        end else begin
          step(1, 1, 0, 0, 0, "R2 sweep start");
          for (int k = 1; k < gap; k++) step(1, 0, 0, 0, 0, "R2 sweep wait");
          step(1, 0, 1, 0, 1, "R2 sweep end");
        end
        step(1, 0, 0, 0, 0, "R2 sweep after done");
        step(0, 0, 0, 0, 0, "R10 sweep fall");
      end
    end

    // R4: long start pulse, then long end pulse.
    step(1, 0, 0, 0, 0, "R4 rise");
    step(1, 1, 0, 0, 0, "R4 start");
    step(1, 1, 0, 1, 0, "R4 start held two cycles");
    step(1, 0, 1, 0, 1, "R4 end still completes");
    step(0, 0, 0, 0, 0, "R4 fall");
    step(1, 0, 0, 0, 0, "R4 rise b");
    step(1, 1, 0, 0, 0, "R4 start b");
    step(1, 0, 1, 0, 1, "R4 end b");
    step(1, 0, 1, 1, 0, "R4 end held two cycles");
    step(0, 0, 0, 0, 0, "R4 fall b");

    // R5: end before start.
    step(1, 0, 0, 0, 0, "R5 rise");
    step(1, 0, 1, 2, 0, "R5 end without start");
    step(0, 0, 0, 0, 0, "R5 fall");

    // R6: second start while waiting; pulse after completion.
    step(1, 0, 0, 0, 0, "R6 rise");
    step(1, 1, 0, 0, 0, "R6 start");
    step(1, 0, 0, 0, 0, "R6 gap");
    step(1, 1, 0, 3, 0, "R6 second start");
    step(1, 0, 1, 0, 1, "R6 end still completes");
    step(1, 0, 1, 1, 0, "R6 end held is long");
    step(1, 0, 0, 0, 0, "R6 quiet");
    step(1, 0, 1, 3, 0, "R6 end after pair");
    step(0, 0, 0, 0, 0, "R6 fall");

    // R7: window dropped while waiting for end; R11 drop beats activity.
    step(1, 0, 0, 0, 0, "R7 rise");
    step(1, 1, 0, 0, 0, "R7 start");
    step(0, 0, 0, 4, 0, "R7 drop mid window");
    step(0, 0, 0, 0, 0, "R7 back to idle");
    step(1, 0, 0, 0, 0, "R11 rise");
    step(1, 1, 0, 0, 0, "R11 start");
    step(0, 0, 1, 4, 0, "R11 drop wins over low activity");
    step(0, 0, 0, 0, 0, "R11 idle");

    // R8: activity while low and in the rising cycle.
    step(0, 1, 0, 5, 0, "R8 start while low");
    step(0, 0, 1, 5, 0, "R8 end while low");
    step(0, 0, 0, 0, 0, "R8 idle");
    step(1, 1, 0, 5, 0, "R8 start in rising cycle");
    step(1, 0, 0, 0, 0, "R8 window open");
    step(1, 1, 1, 0, 1, "R8 later pair legal");
    step(0, 0, 0, 0, 0, "R8 fall");

    // R9: fall while armed is silent.
    step(1, 0, 0, 0, 0, "R9 rise");
    step(1, 0, 0, 0, 0, "R9 armed");
    step(0, 0, 0, 0, 0, "R9 fall no error");

    // R10 and R11: pulses after completion, long beats extra, then a fresh window.
    step(1, 0, 0, 0, 0, "R10 rise");
    step(1, 1, 0, 0, 0, "R10 start");
    step(1, 0, 1, 0, 1, "R10 end");
    step(1, 1, 0, 3, 0, "R11 extra start after pair");
    step(1, 1, 0, 1, 0, "R11 long wins over extra");
    step(0, 0, 0, 0, 0, "R10 fall");
    step(1, 0, 0, 0, 0, "R10 rise again");
    step(1, 1, 1, 0, 1, "R10 new pair after new rise");
    step(0, 0, 0, 0, 0, "R10 fall again");

    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule